// File: doc/BRIEF.md
# FIFO Interrupt Status Register Bank

This block is the small control and status register file of a sixteen-lane sampling front end. Each lane reports three FIFO conditions: a half-full level, a one-cycle overflow event and an empty level. The bank presents these conditions as 32-bit status words on a simple word-addressed read/write bus. It latches overflow events until software clears them by writing ones. It combines both flag groups with two global interrupt enables into a two-bit pending summary and a single interrupt request line.

The same bank also holds the front-end configuration: a two-bit input gain selector and a per-lane convert-enable mask. It provides two write-only strobe bits that fire one-cycle load and clear pulses toward the output converters, a fixed module identification field, and a software reset bit that returns the configuration to its defaults. Reads are combinational from the addressed word. Writes take effect at the clock edge on which `bus_wr_en` is high.

Word addresses: 0 is the board status word, 1 is control, 2 is status word 0 and 3 is status word 1. Every other address is unmapped.

Top module: `fifo_irq_regbank`

## Requirements
- R1: After reset, every configuration bit, sticky flag, strobe and the interrupt line are 0, and the board status word reads only the identification field.
- R2: Status word 0 (address 2) shows the sticky per-lane overflow flags in bits 31..16 (lane n at bit 16+n) and the live per-lane half-full inputs in bits 15..0 (lane n at bit n).
- R3: An overflow event pulse on a lane sets that lane's sticky flag. Writing 1 to its bit in status word 0 clears it, and writing 0 leaves it alone. If an event and a clearing write coincide on a lane, the flag stays set.
- R4: Status word 1 (address 3) shows the live per-lane empty inputs in bits 15..0, with bits 31..16 reading 0. Writes to it change nothing.
- R5: In the control word (address 1), bit 31 is the overflow interrupt enable, bit 30 the half-full interrupt enable, bits 29..28 the gain code (00 ×1, 01 ×2, 10 ×4, 11 ×8) and bits 15..0 the convert enables. These read back as written and drive `gain_sel` and `conv_en` from the cycle after the write.
- R6: Writing 1 to control bit 26 raises `dac_load_pulse`, and writing 1 to bit 25 raises `dac_clear_pulse`. Each pulse lasts exactly the one cycle after the write, and both bits always read 0.
- R7: In the board status word (address 0), bit 1 is 1 when any sticky overflow flag is set and the overflow enable is 1. Bit 0 is 1 when any half-full input is 1 and the half-full enable is 1. Bits 15..13 always read 011.
- R8: `irq` equals the OR of the two pending bits, registered one cycle later.
- R9: Writing 1 to bit 31 of the board status word raises `soft_rst_pulse` for the one following cycle and returns the whole control word to 0. The sticky overflow flags are left as they were.
- R10: All bits not named above read 0. Unmapped addresses read 0, and writes to them have no effect on any readable word or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| ch_half_full | input | NUM_CH | Per-lane FIFO half-full level |
| ch_overflow_evt | input | NUM_CH | Per-lane one-cycle overflow event |
| ch_empty | input | NUM_CH | Per-lane FIFO empty level |
| gain_sel | output | 2 | Input gain code |
| conv_en | output | NUM_CH | Per-lane convert enables |
| dac_load_pulse | output | 1 | One-cycle load strobe |
| dac_clear_pulse | output | 1 | One-cycle clear strobe |
| soft_rst_pulse | output | 1 | One-cycle software reset strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the bank with its defaults: NUM_CH of 16 and ADDR_W of 4. With sixteen lanes every bit of both status halves and the full convert mask is populated, so the lane-to-bit placement of all flags is checked at once. With a four-bit address, twelve unmapped words can be reached, so random writes and reads there exercise the ignore rule alongside the four live words. Random overflow events are mixed with random clearing writes, which repeatedly produces the coincident set-and-clear case.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned LANE_W = 16;

  // word addresses
  localparam int unsigned ADR_BOARD = 0;
  localparam int unsigned ADR_CTRL  = 1;
  localparam int unsigned ADR_STAT0 = 2;
  localparam int unsigned ADR_STAT1 = 3;

  // bit positions decoded by software
  localparam int unsigned BIT_SRST    = 31;
  localparam int unsigned BIT_OVF_IE  = 31;
  localparam int unsigned BIT_HF_IE   = 30;
  localparam int unsigned GAIN_LSB    = 28;
  localparam int unsigned BIT_LOAD    = 26;
  localparam int unsigned BIT_CLR     = 25;
  localparam int unsigned ID_LSB      = 13;
  localparam int unsigned OVF_LSB     = 16;
  localparam int unsigned PEND_OVF    = 1;
  localparam int unsigned PEND_HF     = 0;
  localparam logic [2:0]  MODULE_ID   = 3'b011;

  typedef enum logic [1:0] {
    GAIN_X1 = 2'b00,
    GAIN_X2 = 2'b01,
    GAIN_X4 = 2'b10,
    GAIN_X8 = 2'b11
  } gain_e;

  typedef struct packed {
    logic  ovf_ie;
    logic  hf_ie;
    gain_e gain;
  } ctrl_cfg_t;
endpackage

// File: rtl/irqbank_rst_sync.sv
module irqbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqbank_ctrl_reg.sv
module irqbank_ctrl_reg
  import irqbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              srst_req,
  input  logic [1:0]        ie_bits,     // {ovf, hf}
  input  logic [1:0]        gain_bits,
  input  logic [1:0]        strobe_bits, // {load, clear}
  input  logic [NUM_CH-1:0] conv_bits,
  output ctrl_cfg_t         cfg_q,
  output logic [NUM_CH-1:0] conv_q,
  output logic              load_p,
  output logic              clr_p,
  output logic              srst_p
);
  ctrl_cfg_t         cfg_d;
  logic [NUM_CH-1:0] conv_d;
  logic              cfg_en;
  logic [2:0]        pulse_d;
  logic [2:0]        pulse_q;

  // next state
  always_comb begin
    cfg_en = ctrl_wr | srst_req;
    if (srst_req) begin
      cfg_d  = '0;
      conv_d = '0;
    end else begin
      cfg_d.ovf_ie = ie_bits[1];
      cfg_d.hf_ie  = ie_bits[0];
      cfg_d.gain   = gain_e'(gain_bits);
      conv_d       = conv_bits;
    end
    pulse_d = {ctrl_wr & strobe_bits[1], ctrl_wr & strobe_bits[0], srst_req};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      conv_q <= '0;
    end else if (cfg_en) begin
      cfg_q  <= cfg_d;
      conv_q <= conv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign load_p = pulse_q[2];
  assign clr_p  = pulse_q[1];
  assign srst_p = pulse_q[0];
endmodule

// File: rtl/irqbank_ovf_sticky.sv
module irqbank_ovf_sticky #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] flags_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic flag_r;
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = set_vec[g] | clr_vec[g];
      flag_d  = set_vec[g] | (flag_r & ~clr_vec[g]); // event beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_r <= 1'b0;
      else if (flag_en) flag_r <= flag_d;
    end

    assign flags_q[g] = flag_r;
  end
endmodule

// File: rtl/irqbank_irq_sum.sv
module irqbank_irq_sum #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ovf_flags,
  input  logic [NUM_CH-1:0] hf_flags,
  input  logic              ovf_ie,
  input  logic              hf_ie,
  output logic [1:0]        pend,
  output logic              irq_q
);
  logic irq_d;

  always_comb begin
    pend[1] = (|ovf_flags) & ovf_ie;
    pend[0] = (|hf_flags)  & hf_ie;
    irq_d   = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/fifo_irq_regbank.sv
module fifo_irq_regbank
  import irqbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ch_half_full,
  input  logic [NUM_CH-1:0] ch_overflow_evt,
  input  logic [NUM_CH-1:0] ch_empty,
  output logic [1:0]        gain_sel,
  output logic [NUM_CH-1:0] conv_en,
  output logic              dac_load_pulse,
  output logic              dac_clear_pulse,
  output logic              soft_rst_pulse,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_BOARD = ADDR_W'(ADR_BOARD);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(ADR_STAT0);
  localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(ADR_STAT1);

  logic              rst_sync_n;
  logic              wr_board;
  logic              wr_ctrl;
  logic              wr_stat0;
  logic              srst_req;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] ovf_flags_q;
  logic [1:0]        pend_w;
  ctrl_cfg_t         cfg_q;
  logic [REG_W-1:0]  rd_d;

  irqbank_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // write decode
  always_comb begin
    wr_board = bus_wr_en && (bus_addr == A_BOARD);
    wr_ctrl  = bus_wr_en && (bus_addr == A_CTRL);
    wr_stat0 = bus_wr_en && (bus_addr == A_STAT0);
    srst_req = wr_board && bus_wdata[BIT_SRST];
    clr_vec  = {NUM_CH{wr_stat0}} & bus_wdata[OVF_LSB +: NUM_CH];
  end

  irqbank_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctrl_wr     (wr_ctrl),
    .srst_req    (srst_req),
    .ie_bits     ({bus_wdata[BIT_OVF_IE], bus_wdata[BIT_HF_IE]}),
    .gain_bits   (bus_wdata[GAIN_LSB +: 2]),
    .strobe_bits ({bus_wdata[BIT_LOAD], bus_wdata[BIT_CLR]}),
    .conv_bits   (bus_wdata[NUM_CH-1:0]),
    .cfg_q       (cfg_q),
    .conv_q      (conv_en),
    .load_p      (dac_load_pulse),
    .clr_p       (dac_clear_pulse),
    .srst_p      (soft_rst_pulse)
  );

  irqbank_ovf_sticky #(.NUM_CH(NUM_CH)) u_ovf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (ch_overflow_evt),
    .clr_vec (clr_vec),
    .flags_q (ovf_flags_q)
  );

  irqbank_irq_sum #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ovf_flags (ovf_flags_q),
    .hf_flags  (ch_half_full),
    .ovf_ie    (cfg_q.ovf_ie),
    .hf_ie     (cfg_q.hf_ie),
    .pend      (pend_w),
    .irq_q     (irq)
  );

  assign gain_sel = cfg_q.gain;

  // read multiplexer
  always_comb begin
    rd_d = '0;
    case (bus_addr)
      A_BOARD: begin
        rd_d[ID_LSB +: 3] = MODULE_ID;
        rd_d[PEND_OVF]    = pend_w[1];
        rd_d[PEND_HF]     = pend_w[0];
      end
      A_CTRL: begin
        rd_d[BIT_OVF_IE]    = cfg_q.ovf_ie;
        rd_d[BIT_HF_IE]     = cfg_q.hf_ie;
        rd_d[GAIN_LSB +: 2] = cfg_q.gain;
        rd_d[LANE_W-1:0]    = LANE_W'(conv_en);
      end
      A_STAT0: begin
        rd_d[OVF_LSB +: LANE_W] = LANE_W'(ovf_flags_q);
        rd_d[LANE_W-1:0]        = LANE_W'(ch_half_full);
      end
      A_STAT1: begin
        rd_d[LANE_W-1:0] = LANE_W'(ch_empty);
      end
      default: rd_d = '0;
    endcase
  end

  assign bus_rdata = rd_d;
endmodule

// File: rtl/irqbank_checker.sv
module irqbank_checker #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] ovf_flags,
  input logic [NUM_CH-1:0] ch_overflow_evt,
  input logic [1:0]        pend,
  input logic              irq,
  input logic              dac_load_pulse,
  input logic              dac_clear_pulse,
  input logic              soft_rst_pulse,
  input logic [1:0]        gain_sel,
  input logic [NUM_CH-1:0] conv_en
);
  logic              wr_ctrl_c;
  logic              srst_c;
  logic [NUM_CH-1:0] w1c_mask;

  always_comb begin
    wr_ctrl_c = bus_wr_en && (bus_addr == ADDR_W'(1));
    srst_c    = bus_wr_en && (bus_addr == '0) && bus_wdata[31];
    w1c_mask  = (bus_wr_en && (bus_addr == ADDR_W'(2))) ? bus_wdata[16 +: NUM_CH] : '0;
  end

  a_r6_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load_pulse |-> $past(wr_ctrl_c && bus_wdata[26]));

  a_r6_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dac_clear_pulse |-> $past(wr_ctrl_c && bus_wdata[25]));

  a_r9_srst_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $past(srst_c));

  a_r9_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (gain_sel == 2'b00 && conv_en == '0));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & ~$past(ovf_flags) & ~$past(ch_overflow_evt)) == '0));

  a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ovf_flags) & ~ovf_flags & ~$past(w1c_mask)) == '0));

  a_r8_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|pend)));

  a_r7_module_id: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata[15:13] == 3'b011));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(3)) |-> (bus_rdata == '0));
endmodule

bind fifo_irq_regbank irqbank_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .bus_wr_en       (bus_wr_en),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .ovf_flags       (ovf_flags_q),
  .ch_overflow_evt (ch_overflow_evt),
  .pend            (pend_w),
  .irq             (irq),
  .dac_load_pulse  (dac_load_pulse),
  .dac_clear_pulse (dac_clear_pulse),
  .soft_rst_pulse  (soft_rst_pulse),
  .gain_sel        (gain_sel),
  .conv_en         (conv_en)
);

// File: tb/fifo_irq_regbank_tb_top.sv
`timescale 1ns/100ps
module fifo_irq_regbank_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ch_half_full;
  logic [15:0] ch_overflow_evt;
  logic [15:0] ch_empty;
  logic [1:0]  gain_sel;
  logic [15:0] conv_en;
  logic        dac_load_pulse;
  logic        dac_clear_pulse;
  logic        soft_rst_pulse;
  logic        irq;

  int n_checks;
  int n_errors;
  bit done;

  // bench model
  logic        m_ovf_ie, m_hf_ie;
  logic [1:0]  m_gain;
  logic [15:0] m_conv, m_ovf, m_hf, m_emp;

  fifo_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_half_full(ch_half_full),
    .ch_overflow_evt(ch_overflow_evt), .ch_empty(ch_empty), .gain_sel(gain_sel),
    .conv_en(conv_en), .dac_load_pulse(dac_load_pulse), .dac_clear_pulse(dac_clear_pulse),
    .soft_rst_pulse(soft_rst_pulse), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_board();
    logic [31:0] v = 32'h0;
    v[15:13] = 3'b011;
    v[1] = m_ovf_ie & (|m_ovf);
    v[0] = m_hf_ie & (|m_hf);
    return v;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {m_ovf_ie, m_hf_ie, m_gain, 12'h000, m_conv};
  endfunction

  function automatic logic [31:0] exp_stat0();
    return {m_ovf, m_hf};
  endfunction

  function automatic logic [31:0] exp_stat1();
    return {16'h0000, m_emp};
  endfunction

  function automatic logic exp_irq();
    return (m_ovf_ie & (|m_ovf)) | (m_hf_ie & (|m_hf));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic read_chk(input logic [3:0] a, input string tag, input logic [31:0] expv);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, expv);
  endtask

  task automatic check_all();
    chk("R8 irq", {31'h0, irq}, {31'h0, exp_irq()});
    read_chk(4'd0, "R7 board status", exp_board());
    read_chk(4'd1, "R5 control readback", exp_ctrl());
    read_chk(4'd2, "R2 status word 0", exp_stat0());
    read_chk(4'd3, "R4 status word 1", exp_stat1());
    read_chk(4'(4 + ($urandom % 12)), "R10 unmapped read", 32'h0);
  endtask

  // one bus operation plus one settling cycle, then full check
  task automatic op(input bit wr, input logic [3:0] a, input logic [31:0] d,
                    input logic [15:0] evt, input logic [15:0] hf_n, input logic [15:0] emp_n);
    logic e_load, e_clr, e_srst;
    @(negedge clk);
    bus_wr_en = wr; bus_addr = a; bus_wdata = d;
    ch_overflow_evt = evt; ch_half_full = hf_n; ch_empty = emp_n;
    @(negedge clk);
    bus_wr_en = 1'b0; ch_overflow_evt = '0;
    e_load = wr && a == 4'd1 && d[26];
    e_clr  = wr && a == 4'd1 && d[25];
    e_srst = wr && a == 4'd0 && d[31];
    chk("R6 load pulse", {31'h0, dac_load_pulse}, {31'h0, e_load});
    chk("R6 clear pulse", {31'h0, dac_clear_pulse}, {31'h0, e_clr});
    chk("R9 soft reset pulse", {31'h0, soft_rst_pulse}, {31'h0, e_srst});
    if (wr && a == 4'd1) begin
      m_ovf_ie = d[31]; m_hf_ie = d[30]; m_gain = d[29:28]; m_conv = d[15:0];
    end
    if (e_srst) begin
      m_ovf_ie = 1'b0; m_hf_ie = 1'b0; m_gain = 2'b00; m_conv = 16'h0;
    end
    m_ovf = (m_ovf & ~((wr && a == 4'd2) ? d[31:16] : 16'h0)) | evt;
    m_hf  = hf_n;
    m_emp = emp_n;
    chk("R5 gain_sel", {30'h0, gain_sel}, {30'h0, m_gain});
    chk("R5 conv_en", {16'h0, conv_en}, {16'h0, m_conv});
    @(negedge clk);
    chk("R6 load pulse single cycle", {31'h0, dac_load_pulse}, 32'h0);
    chk("R6 clear pulse single cycle", {31'h0, dac_clear_pulse}, 32'h0);
    chk("R9 soft reset single cycle", {31'h0, soft_rst_pulse}, 32'h0);
    check_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0;
    bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    ch_half_full = '0; ch_overflow_evt = '0; ch_empty = '0;
    m_ovf_ie = 0; m_hf_ie = 0; m_gain = 0; m_conv = 0; m_ovf = 0; m_hf = 0; m_emp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 gain after reset", {30'h0, gain_sel}, 32'h0);
    chk("R1 conv after reset", {16'h0, conv_en}, 32'h0);
    chk("R1 strobes after reset", {29'h0, dac_load_pulse, dac_clear_pulse, soft_rst_pulse}, 32'h0);
    read_chk(4'd0, "R1 board status after reset", 32'h0000_6000);
    read_chk(4'd1, "R1 control after reset", 32'h0);
    read_chk(4'd2, "R1 status0 after reset", 32'h0);

    // R5/R6/R10: control with every bit set, strobes and reserved bits masked
    op(1, 4'd1, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h0);
    // R3: event sets, zero write keeps, coincident clear loses, plain clear works
    op(0, 4'd0, 32'h0, 16'h0008, 16'h0, 16'h0);
    op(1, 4'd2, 32'h0000_FFFF, 16'h0, 16'h0, 16'h0);
    op(1, 4'd2, 32'h0008_0000, 16'h0008, 16'h0, 16'h0);
    read_chk(4'd2, "R3 set wins over clear", 32'h0008_0000);
    op(1, 4'd2, 32'h0008_0000, 16'h0, 16'h0, 16'h0);
    // R7/R8 half-full pending with and without its enable
    op(1, 4'd1, 32'h4000_0000, 16'h0, 16'h8001, 16'hF00F);
    op(1, 4'd1, 32'h0000_0000, 16'h0, 16'h8001, 16'hF00F);
    // R4/R10 writes to status1 and unmapped words ignored
    op(1, 4'd3, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h00FF);
    op(1, 4'd9, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h00FF);
    // R9 soft reset clears control, keeps overflow flags
    op(1, 4'd1, 32'hB000_1234, 16'h4000, 16'h0, 16'h0);
    op(1, 4'd0, 32'h8000_0000, 16'h0, 16'h0, 16'h0);
    read_chk(4'd2, "R9 overflow kept across soft reset", 32'h4000_0000);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int unsigned sel = $urandom % 6;
      logic [31:0] d = $urandom;
      logic [15:0] evt = 16'($urandom & $urandom & $urandom);
      logic [15:0] hf = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom & $urandom);
      logic [15:0] em = 16'($urandom);
      case (sel)
        0: op(1, 4'd1, d, evt, hf, em);
        1: op(1, 4'd2, d, evt, hf, em);
        2: op(1, 4'd0, ($urandom % 4 == 0) ? d : (d & 32'h7FFF_FFFF), evt, hf, em);
        3: op(1, 4'(4 + ($urandom % 12)), d, evt, hf, em);
        4: op(1, 4'd3, d, evt, hf, em);
        default: op(0, 4'd0, d, evt, hf, em);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule